// File: doc/BRIEF.md
# Pipelined Bus Transfer Tracker

A passive observer for a single-manager pipelined system bus in which every transfer has an address/control phase followed by a data phase one clock later. The tracker samples the address, transfer type, direction and size on the cycle the address phase is accepted. It holds them in a pending register, then joins them with the write or read data seen in the cycle that completes the following data phase. Each joined transfer leaves the block as a one-clock record. The tracker never pairs address and data taken from the same cycle, because in any cycle the two buses belong to different transfers.

Alongside the records, the tracker keeps four saturating counters: completed transfers, bubble cycles (bus ready but no data phase pending), stalled cycles (bus not ready) and total cycles. Comparing completed transfers with total cycles shows how far the bus falls short of the one-transfer-per-cycle ceiling. The tracker also raises an error pulse when the bus completes a data phase that no accepted address phase started.

The control is a three-state machine. ST_EMPTY means no data phase is pending. ST_DATA means a data phase is pending. ST_ORPHAN means the bus is stretching a data phase that no address started. The transitions are as follows:
- Ready low in ST_EMPTY goes to ST_ORPHAN.
- An accepted address goes from any state to ST_DATA.
- Ready high with no accepted address goes from ST_DATA or ST_ORPHAN to ST_EMPTY.
- Ready low in ST_DATA stays in ST_DATA, and ready low in ST_ORPHAN stays in ST_ORPHAN.
- Ready high with no accepted address keeps ST_EMPTY in ST_EMPTY.

Top module: `bus_xfer_tracker`

## Requirements
- R1: An address phase is accepted only in a cycle where `bus_ready` is 1 and `bus_trans` is 2'b10 (first beat) or 2'b11 (sequential beat). Type 2'b00 (idle) and 2'b01 (busy) start no transfer and produce no later record.
- R2: A record carries the address, direction and size sampled in the accepting cycle. Its data comes from the following cycle in which `bus_ready` is 1, never from the accepting cycle itself. An isolated access therefore takes two bus cycles, with its record visible after the second.
- R3: The record data is `bus_wdata` when the accepted direction was write (`bus_write` = 1) and `bus_rdata` when it was read. The data is sampled in the completing cycle.
- R4: `rec_valid` is 1 for exactly one clock per completed transfer, in the cycle after completion. Back-to-back accepted address phases yield one record per cycle.
- R5: While `bus_ready` is 0 the pending data phase is extended. No record is produced, an address presented during the stall is not accepted, and the stall counter advances.
- R6: If `bus_ready` is 0 while no data phase is pending, the tracker treats it as an orphan data phase. The cycle in which `bus_ready` returns to 1 produces a one-clock `orphan_err` pulse in the next cycle, and no record.
- R7: Counters: `cnt_done` counts cycles that complete a pending data phase. `cnt_bubble` counts cycles with `bus_ready` = 1 and nothing pending, including the first fill cycle. `cnt_stall` counts cycles with `bus_ready` = 0. `cnt_cycles` counts every cycle. Until saturation, cycles = done + bubble + stall.
- R8: Each counter is `CNT_W` bits wide (32 by default) and holds at its all-ones value instead of wrapping.
- R9: A synchronous active-low reset `rst_n` clears the state to ST_EMPTY, clears `rec_valid` and `orphan_err`, and zeroes all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Address bus |
| bus_trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 first beat, 11 sequential beat |
| bus_write | input | 1 | Direction, 1 = write |
| bus_size | input | 3 | Transfer size code |
| bus_ready | input | 1 | Data phase completes when 1 |
| bus_wdata | input | DW | Write data bus |
| bus_rdata | input | DW | Read data bus |
| rec_valid | output | 1 | One-clock strobe for a completed transfer record |
| rec_addr | output | AW | Record address |
| rec_write | output | 1 | Record direction |
| rec_size | output | 3 | Record size code |
| rec_data | output | DW | Record data |
| orphan_err | output | 1 | One-clock pulse for a data phase with no address phase |
| cnt_done | output | CNT_W | Completed transfers |
| cnt_bubble | output | CNT_W | Bubble cycles |
| cnt_stall | output | CNT_W | Stalled cycles |
| cnt_cycles | output | CNT_W | Total cycles |

## Verification
On every cycle, the assertions check the following:
- An accepted address moves the machine to ST_DATA.
- Idle and busy types never start a data phase.
- A completion is followed by a record strobe, and a stall is never followed by one.
- An error pulse only follows a completing orphan state.
- The counters never decrease and partition the total cycle count.

Only the bench's scenarios can show that the record fields carry the correct diagonal pairing: control from one cycle, data from the next ready cycle, with write or read data chosen correctly. The scenarios also show that an address offered during a stall is discarded in favour of the one presented on the ready cycle, and that the counters saturate and clear.

// File: rtl/tracker_pkg.sv
package tracker_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_DATA   = 2'd1,
        ST_ORPHAN = 2'd2
    } phase_e;

    localparam logic [1:0] TR_NSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ  = 2'b11;

    localparam int NUM_CNT   = 4;
    localparam int IDX_DONE  = 0;
    localparam int IDX_BUB   = 1;
    localparam int IDX_STALL = 2;
    localparam int IDX_CYC   = 3;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end

    // R8: never decreases outside reset
    a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt >= $past(cnt)));
    // R8: holds at all-ones
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV) |=> (cnt == MAXV));
endmodule

// File: rtl/xfer_phase_fsm.sv
module xfer_phase_fsm
    import tracker_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_trans,
    input  logic          bus_write,
    input  logic [2:0]    bus_size,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          rec_valid,
    output logic [AW-1:0] rec_addr,
    output logic          rec_write,
    output logic [2:0]    rec_size,
    output logic [DW-1:0] rec_data,
    output logic          orphan_err,
    output logic          ev_done,
    output logic          ev_bubble,
    output logic          ev_stall
);
    phase_e        state_q, state_d;
    logic          accept;
    logic [AW-1:0] pend_addr;
    logic          pend_write;
    logic [2:0]    pend_size;

    // Next-state logic
    always_comb begin
        accept  = bus_ready && (bus_trans == TR_NSEQ || bus_trans == TR_SEQ);
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (!bus_ready)  state_d = ST_ORPHAN;
                else if (accept) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bus_ready) state_d = accept ? ST_DATA : ST_EMPTY;
            end
            ST_ORPHAN: begin
                if (bus_ready) state_d = accept ? ST_DATA : ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Pending address-phase control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr  <= '0;
            pend_write <= 1'b0;
            pend_size  <= '0;
        end else if (accept) begin
            pend_addr  <= bus_addr;
            pend_write <= bus_write;
            pend_size  <= bus_size;
        end
    end

    assign ev_done   = (state_q == ST_DATA) && bus_ready;
    assign ev_bubble = (state_q != ST_DATA) && bus_ready;
    assign ev_stall  = !bus_ready;

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_addr   <= '0;
            rec_write  <= 1'b0;
            rec_size   <= '0;
            rec_data   <= '0;
            orphan_err <= 1'b0;
        end else begin
            rec_valid  <= ev_done;
            orphan_err <= (state_q == ST_ORPHAN) && bus_ready;
            if (ev_done) begin
                rec_addr  <= pend_addr;
                rec_write <= pend_write;
                rec_size  <= pend_size;
                rec_data  <= pend_write ? bus_wdata : bus_rdata;
            end
        end
    end

    // R1: a qualified address phase opens a data phase
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_trans[1]) |=> (state_q == ST_DATA));
    // R1: idle/busy never open a data phase
    a_r1_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && !bus_trans[1]) |=> (state_q != ST_DATA));
    // R4: completion gives a record next cycle
    a_r4_record: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && bus_ready) |=> rec_valid);
    // R5: stall keeps the pending control and emits nothing
    a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && !bus_ready) |=>
            (state_q == ST_DATA && !rec_valid && $stable(pend_addr)));
    // R2: record address is the control held before completion
    a_r2_diag: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA) && bus_ready) |=> (rec_addr == $past(pend_addr)));
    // R6: error pulse only after a completing orphan phase
    a_r6_err_src: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_ORPHAN) || !bus_ready) |=> !orphan_err);
endmodule

// File: rtl/bus_xfer_tracker.sv
module bus_xfer_tracker
    import tracker_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [1:0]       bus_trans,
    input  logic             bus_write,
    input  logic [2:0]       bus_size,
    input  logic             bus_ready,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    output logic             rec_valid,
    output logic [AW-1:0]    rec_addr,
    output logic             rec_write,
    output logic [2:0]       rec_size,
    output logic [DW-1:0]    rec_data,
    output logic             orphan_err,
    output logic [CNT_W-1:0] cnt_done,
    output logic [CNT_W-1:0] cnt_bubble,
    output logic [CNT_W-1:0] cnt_stall,
    output logic [CNT_W-1:0] cnt_cycles
);
    localparam int SUM_W = CNT_W + 2;

    logic             ev_done, ev_bubble, ev_stall;
    logic [NUM_CNT-1:0] inc;
    logic [CNT_W-1:0] cnt_arr [NUM_CNT];

    xfer_phase_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_trans  (bus_trans),
        .bus_write  (bus_write),
        .bus_size   (bus_size),
        .bus_ready  (bus_ready),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rec_valid  (rec_valid),
        .rec_addr   (rec_addr),
        .rec_write  (rec_write),
        .rec_size   (rec_size),
        .rec_data   (rec_data),
        .orphan_err (orphan_err),
        .ev_done    (ev_done),
        .ev_bubble  (ev_bubble),
        .ev_stall   (ev_stall)
    );

    always_comb begin
        inc            = '0;
        inc[IDX_DONE]  = ev_done;
        inc[IDX_BUB]   = ev_bubble;
        inc[IDX_STALL] = ev_stall;
        inc[IDX_CYC]   = 1'b1;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[i]),
            .cnt   (cnt_arr[i])
        );
    end

    assign cnt_done   = cnt_arr[IDX_DONE];
    assign cnt_bubble = cnt_arr[IDX_BUB];
    assign cnt_stall  = cnt_arr[IDX_STALL];
    assign cnt_cycles = cnt_arr[IDX_CYC];

    // R7: counters partition total cycles until saturation
    a_r7_partition: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cycles != '1) |->
            (SUM_W'(cnt_cycles) == SUM_W'(cnt_done) + SUM_W'(cnt_bubble) + SUM_W'(cnt_stall)));
    // R6/R4: error and record never coincide
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(orphan_err && rec_valid));
endmodule

// File: tb/tb_bus_xfer_tracker.sv
module tb_bus_xfer_tracker;
    localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  trans = T_IDLE;
    logic        wr = 1'b0;
    logic [2:0]  sz = '0;
    logic        rdy = 1'b1;
    logic [31:0] wd = '0, rd = '0;

    logic        rv, rw, oe;
    logic [31:0] ra, rdat;
    logic [2:0]  rs;
    logic [31:0] c_done, c_bub, c_stall, c_cyc;
    logic        s_rv, s_rw, s_oe;
    logic [31:0] s_ra, s_rd;
    logic [2:0]  s_rs;
    logic [3:0]  s_done, s_bub, s_stall, s_cyc;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bus_xfer_tracker dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_trans(trans), .bus_write(wr),
        .bus_size(sz), .bus_ready(rdy), .bus_wdata(wd), .bus_rdata(rd),
        .rec_valid(rv), .rec_addr(ra), .rec_write(rw), .rec_size(rs), .rec_data(rdat),
        .orphan_err(oe), .cnt_done(c_done), .cnt_bubble(c_bub), .cnt_stall(c_stall),
        .cnt_cycles(c_cyc));

    bus_xfer_tracker #(.CNT_W(4)) dut_small (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_trans(trans), .bus_write(wr),
        .bus_size(sz), .bus_ready(rdy), .bus_wdata(wd), .bus_rdata(rd),
        .rec_valid(s_rv), .rec_addr(s_ra), .rec_write(s_rw), .rec_size(s_rs), .rec_data(s_rd),
        .orphan_err(s_oe), .cnt_done(s_done), .cnt_bubble(s_bub), .cnt_stall(s_stall),
        .cnt_cycles(s_cyc));

    typedef struct {
        logic        v;
        logic [31:0] a;
        logic        w;
        logic [2:0]  s;
        logic [31:0] d;
        logic        e;
    } exp_t;
    exp_t q[$];

    // bench model state
    bit          m_pend, m_orph, m_pw;
    logic [31:0] m_pa;
    logic [2:0]  m_ps;
    int          e_done, e_bub, e_stall, e_cyc;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_pend = 0; m_orph = 0; m_pw = 0; m_pa = '0; m_ps = '0;
        e_done = 0; e_bub = 0; e_stall = 0; e_cyc = 0;
    endtask

    // driver: one bus cycle, pushes the expected outcome
    task automatic cyc(input logic [1:0] t, input logic [31:0] a, input logic w,
                       input logic [2:0] s, input logic [31:0] wdv, input logic [31:0] rdv,
                       input logic r);
        exp_t it;
        @(negedge clk);
        trans = t; addr = a; wr = w; sz = s; wd = wdv; rd = rdv; rdy = r;
        it.v = r && m_pend;
        it.a = m_pa; it.w = m_pw; it.s = m_ps;
        it.d = m_pw ? wdv : rdv;
        it.e = r && m_orph;
        q.push_back(it);
        e_cyc++;
        if (!r) e_stall++;
        else if (m_pend) e_done++;
        else e_bub++;
        if (r) begin
            m_orph = 0;
            if (t[1]) begin m_pend = 1; m_pa = a; m_pw = w; m_ps = s; end
            else m_pend = 0;
        end else if (!m_pend) begin
            m_orph = 1;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 32'h0, 32'h0, 1'b1);
    endtask

    task automatic chk_cnt(input string tag);
        #1;
        check(c_done == e_done, "R7", {tag, " done"}, c_done, e_done);
        check(c_bub == e_bub, "R7", {tag, " bubble"}, c_bub, e_bub);
        check(c_stall == e_stall, "R7", {tag, " stall"}, c_stall, e_stall);
        check(c_cyc == e_cyc, "R7", {tag, " cycles"}, c_cyc, e_cyc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; trans = T_IDLE; rdy = 1'b1;
        q.delete();
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        // reset-release cycle is counted by the design
        e_cyc = 1; e_bub = 1;
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (q.size() == 0) begin
                check(!rv, "R4", "unexpected record", {31'b0, rv}, 32'h0);
                check(!oe, "R6", "unexpected error", {31'b0, oe}, 32'h0);
            end else begin
                exp_t it;
                it = q.pop_front();
                check(rv == it.v, "R4", "record strobe", {31'b0, rv}, {31'b0, it.v});
                check(oe == it.e, "R6", "orphan pulse", {31'b0, oe}, {31'b0, it.e});
                if (it.v && rv) begin
                    check(ra == it.a, "R2", "record address", ra, it.a);
                    check(rw == it.w, "R2", "record direction", {31'b0, rw}, {31'b0, it.w});
                    check(rs == it.s, "R2", "record size", {29'b0, rs}, {29'b0, it.s});
                    check(rdat == it.d, "R3", "record data", rdat, it.d);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk);
        e_cyc = 1; e_bub = 1;
        #1;
        // R9: reset state
        check(!rv && !oe, "R9", "outputs after reset", {30'b0, rv, oe}, 32'h0);
        check(c_done == 0 && c_stall == 0, "R9", "counters after reset", c_done, 32'h0);

        // R2, R3: isolated write then isolated read
        cyc(T_NSEQ, 32'h1000, 1'b1, 3'd2, 32'hAAAA_0000, 32'hDEAD_0000, 1'b1);
        cyc(T_IDLE, 32'h9999, 1'b0, 3'd0, 32'h1111_2222, 32'h3333_4444, 1'b1);
        cyc(T_NSEQ, 32'h2000, 1'b0, 3'd1, 32'h5555_6666, 32'h7777_8888, 1'b1);
        cyc(T_IDLE, 32'h0,    1'b1, 3'd0, 32'h9999_AAAA, 32'hBBBB_CCCC, 1'b1);
        idle(2);
        chk_cnt("R7 isolated");

        // R4: back-to-back reads, one record per cycle
        cyc(T_NSEQ, 32'h3000, 1'b0, 3'd2, 32'h0, 32'h0000_0001, 1'b1);
        cyc(T_SEQ,  32'h3004, 1'b0, 3'd2, 32'h0, 32'h0000_00D0, 1'b1);
        cyc(T_SEQ,  32'h3008, 1'b0, 3'd2, 32'h0, 32'h0000_00D1, 1'b1);
        cyc(T_SEQ,  32'h300C, 1'b1, 3'd2, 32'hFACE_0000, 32'h0000_00D2, 1'b1);
        cyc(T_IDLE, 32'h0,    1'b0, 3'd0, 32'hFACE_0001, 32'h0000_00D3, 1'b1);
        idle(1);
        chk_cnt("R4 stream");

        // R1: busy and idle mid-stream start nothing
        cyc(T_NSEQ, 32'h4000, 1'b1, 3'd0, 32'h0, 32'h0, 1'b1);
        cyc(T_BUSY, 32'h4001, 1'b1, 3'd0, 32'h0000_00B1, 32'h0, 1'b1);
        cyc(T_IDLE, 32'h4002, 1'b1, 3'd0, 32'h0000_00B2, 32'h0, 1'b1);
        cyc(T_SEQ,  32'h4003, 1'b1, 3'd0, 32'h0000_00B3, 32'h0, 1'b1);
        cyc(T_IDLE, 32'h0,    1'b0, 3'd0, 32'h0000_00B4, 32'h0, 1'b1);
        idle(1);
        chk_cnt("R1 bubble");

        // R5: wait states; address offered during stall is not accepted
        cyc(T_NSEQ, 32'h5000, 1'b1, 3'd2, 32'h0, 32'h0, 1'b1);
        cyc(T_NSEQ, 32'hBAD0, 1'b0, 3'd2, 32'h0000_0E01, 32'h0, 1'b0);
        cyc(T_NSEQ, 32'hBAD4, 1'b0, 3'd2, 32'h0000_0E02, 32'h0, 1'b0);
        cyc(T_NSEQ, 32'h5100, 1'b0, 3'd1, 32'h0000_0E03, 32'h0, 1'b1);
        cyc(T_IDLE, 32'h0,    1'b0, 3'd0, 32'h0, 32'h0000_0F00, 1'b0);
        cyc(T_IDLE, 32'h0,    1'b0, 3'd0, 32'h0, 32'h0000_0F01, 1'b1);
        idle(1);
        chk_cnt("R5 stall");

        // R6: orphan data phase
        idle(1);
        cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 32'h0, 32'h0, 1'b0);
        cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 32'h0, 32'h0, 1'b0);
        cyc(T_NSEQ, 32'h6000, 1'b0, 3'd2, 32'h0, 32'h0, 1'b1);
        cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 32'h0, 32'h0000_6666, 1'b1);
        idle(2);
        chk_cnt("R6 orphan");

        // R8: saturation on the 4-bit instance
        do_reset();
        idle(20);
        #1;
        check(s_cyc == 4'hF, "R8", "small cycles saturate", {28'b0, s_cyc}, 32'hF);
        check(s_bub == 4'hF, "R8", "small bubble saturate", {28'b0, s_bub}, 32'hF);
        check(c_cyc == e_cyc, "R8", "wide counter no saturation", c_cyc, e_cyc);

        // R9: mid-run reset clears pending state and counters
        cyc(T_NSEQ, 32'h7000, 1'b1, 3'd2, 32'h0, 32'h0, 1'b1);
        do_reset();
        #1;
        check(c_done == 0 && c_stall == 0, "R9", "counters cleared", c_done, 32'h0);
        check(c_cyc == 1, "R9", "cycle count restarts", c_cyc, 32'h1);
        idle(2);
        chk_cnt("R9 after reset");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule